// File: doc/BRIEF.md
# DS1 Superframe Framer with Robbed-Bit Signalling

This block builds the serial bit stream of a 24-channel primary-rate line frame. One frame is a single framing bit followed by one eight-bit word from each channel in turn. Twelve frames make a superframe. The framing bit carries a terminal pattern in the odd-numbered frames and a superframe pattern in the even-numbered frames. In frame 6 and frame 12 the last bit of every channel word is replaced by that channel's signalling bit A or B. Every word is then guarded against long zero runs: if all of its bits other than bit 7 are zero, bit 7 is sent as one.

The framer runs on the line bit clock and emits one bit per cycle. Channel bytes are pulled from the source with a request strobe, one cycle before each word begins. The strobe names the channel whose byte is wanted. Two strobes mark the framing bit of every frame and the framing bit of frame 1. Bits are numbered 1 to 8 from the MSB, so bit 8 is the LSB.

Top module: `ds1_sf_framer`

## Requirements
- R1: While `rst` is high, `ser_out`, `frame_sync`, `sf_sync` and `byte_req` are 0. The first bit out after `rst` falls is the framing bit of frame 1.
- R2: A frame lasts 1 + 8*NUM_CH cycles. `frame_sync` is 1 exactly in the cycles where `ser_out` carries a framing bit.
- R3: `sf_sync` is 1 only in the framing-bit cycle of frame 1. It repeats every 12 frames.
- R4: The framing bit of frames 1,3,5,7,9,11 is 1,0,1,0,1,0. The framing bit of frames 2,4,6,8,10,12 is 0,0,1,1,1,0.
- R5: `byte_req` is 1 for one cycle before each channel word starts. `byte_in` is sampled at the clock edge that ends that cycle and is ignored in all other cycles. The word then appears on `ser_out` over the next 8 cycles, MSB first.
- R6: In frame 6, bit 8 (the LSB) of each word is replaced by `sig_a[ch]`. In frame 12 it is replaced by `sig_b[ch]`. Both are sampled at the same edge as the byte.
- R7: In the other ten frames, bit 8 is the LSB of the byte, and `sig_a` and `sig_b` have no effect on the output.
- R8: After the bit-8 substitution, if bits 1 to 6 and bit 8 of the word are all 0, bit 7 (`word[1]`) is sent as 1. Otherwise the word is sent unchanged. This holds in every frame.
- R9: Within a frame, `req_ch` runs 0,1,...,NUM_CH-1, one value per request. The first request of a frame falls in the framing-bit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_req | output | 1 | Request for the next channel byte |
| req_ch | output | CH_W | Index of the channel being requested |
| byte_in | input | 8 | Channel byte, sampled while `byte_req` is high |
| sig_a | input | NUM_CH | Signalling bit A of each channel |
| sig_b | input | NUM_CH | Signalling bit B of each channel |
| ser_out | output | 1 | Serial line bit |
| frame_sync | output | 1 | Marks the framing bit of each frame |
| sf_sync | output | 1 | Marks the framing bit of frame 1 |

## Verification
The bench builds the framer with NUM_CH=3, which gives a 25-bit frame and a 300-bit superframe. This lets one short run cross three full superframes. Every framing bit, both robbed frames and the wrap from the last channel back to the framing bit are covered several times. The byte pattern includes zero bytes, bytes with only bit 8 set, and bytes with only bit 7 set, in both robbed and plain frames, so the zero guard is seen both firing and being cancelled by a robbed one. A reset in the middle of a frame shows the restart at frame 1.

// File: rtl/ds1_sf_pkg.sv
package ds1_sf_pkg;

    localparam int CH_BITS       = 8;
    localparam int FRAMES_PER_SF = 12;
    localparam int ROB_A_FRM     = 5;   // frame 6, zero-based
    localparam int ROB_B_FRM     = 11;  // frame 12, zero-based

    // bit i is the framing bit of the i-th odd (resp. even) frame
    localparam logic [5:0] TERM_PAT = 6'b010101;
    localparam logic [5:0] SUPR_PAT = 6'b011100;

    typedef logic [3:0] frame_idx_t;
    typedef logic [2:0] bit_idx_t;
    typedef logic [CH_BITS-1:0] word_t;

    typedef enum logic [1:0] {
        ROB_NONE = 2'd0,
        ROB_A    = 2'd1,
        ROB_B    = 2'd2
    } rob_kind_t;

    typedef struct packed {
        logic       at_s;
        frame_idx_t frm;
        bit_idx_t   bitn;
    } slot_pos_t;

    function automatic logic framing_bit(frame_idx_t frm);
        logic bval;
        if (frm[0] == 1'b0)
            bval = TERM_PAT[frm[3:1]];
        else
            bval = SUPR_PAT[frm[3:1]];
        return bval;
    endfunction

    function automatic rob_kind_t rob_of(frame_idx_t frm);
        rob_kind_t r;
        if (frm == frame_idx_t'(ROB_A_FRM))
            r = ROB_A;
        else if (frm == frame_idx_t'(ROB_B_FRM))
            r = ROB_B;
        else
            r = ROB_NONE;
        return r;
    endfunction

    function automatic word_t condition_word(word_t raw, rob_kind_t r,
                                             logic a, logic b);
        word_t w;
        w = raw;
        case (r)
            ROB_A:   w[0] = a;
            ROB_B:   w[0] = b;
            default: w[0] = raw[0];
        endcase
        if (w[7:2] == 6'd0 && w[0] == 1'b0)
            w[1] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/ds1_slot_timer.sv
module ds1_slot_timer
    import ds1_sf_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 5
) (
    input  logic            clk,
    input  logic            rst,
    output slot_pos_t       pos,
    output logic [CH_W-1:0] ch
);

    localparam logic [CH_W-1:0] LAST_CH  = CH_W'(NUM_CH - 1);
    localparam frame_idx_t      LAST_FRM = frame_idx_t'(FRAMES_PER_SF - 1);
    localparam bit_idx_t        LAST_BIT = bit_idx_t'(CH_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos.at_s <= 1'b1;
            pos.frm  <= '0;
            pos.bitn <= '0;
            ch       <= '0;
        end else if (pos.at_s) begin
            pos.at_s <= 1'b0;
            pos.bitn <= '0;
            ch       <= '0;
        end else if (pos.bitn == LAST_BIT) begin
            pos.bitn <= '0;
            if (ch == LAST_CH) begin
                pos.at_s <= 1'b1;
                ch       <= '0;
                pos.frm  <= (pos.frm == LAST_FRM) ? '0 : pos.frm + 4'd1;
            end else begin
                ch <= ch + CH_W'(1);
            end
        end else begin
            pos.bitn <= pos.bitn + 3'd1;
        end
    end

endmodule

// File: rtl/ds1_word_cond.sv
module ds1_word_cond
    import ds1_sf_pkg::*;
(
    input  word_t      raw,
    input  frame_idx_t frm,
    input  logic       sa,
    input  logic       sb,
    output word_t      sent
);

    rob_kind_t kind;

    always_comb begin
        kind = rob_of(frm);
        sent = condition_word(raw, kind, sa, sb);
    end

endmodule

// File: rtl/ds1_bit_shifter.sv
module ds1_bit_shifter
    import ds1_sf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_s,
    input  logic  s_val,
    input  logic  s_first,
    input  logic  load_word,
    input  word_t word,
    output logic  ser_out,
    output logic  frame_sync,
    output logic  sf_sync
);

    logic [CH_BITS-2:0] rest_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out    <= 1'b0;
            frame_sync <= 1'b0;
            sf_sync    <= 1'b0;
            rest_q     <= '0;
        end else begin
            frame_sync <= load_s;
            sf_sync    <= load_s & s_first;
            if (load_s) begin
                ser_out <= s_val;
            end else if (load_word) begin
                ser_out <= word[CH_BITS-1];
                rest_q  <= word[CH_BITS-2:0];
            end else begin
                ser_out <= rest_q[CH_BITS-2];
                rest_q  <= {rest_q[CH_BITS-3:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/ds1_sf_framer.sv
module ds1_sf_framer
    import ds1_sf_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              byte_req,
    output logic [CH_W-1:0]   req_ch,
    input  logic [7:0]        byte_in,
    input  logic [NUM_CH-1:0] sig_a,
    input  logic [NUM_CH-1:0] sig_b,
    output logic              ser_out,
    output logic              frame_sync,
    output logic              sf_sync
);

    slot_pos_t       pos;
    logic [CH_W-1:0] ch;
    word_t           sent;
    logic            s_val;
    logic            s_first;

    ds1_slot_timer #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) timer_i (
        .clk (clk),
        .rst (rst),
        .pos (pos),
        .ch  (ch)
    );

    ds1_word_cond cond_i (
        .raw  (byte_in),
        .frm  (pos.frm),
        .sa   (sig_a[ch]),
        .sb   (sig_b[ch]),
        .sent (sent)
    );

    always_comb begin
        byte_req = ~pos.at_s && (pos.bitn == '0);
        req_ch   = ch;
        s_val    = framing_bit(pos.frm);
        s_first  = (pos.frm == '0);
    end

    ds1_bit_shifter shift_i (
        .clk        (clk),
        .rst        (rst),
        .load_s     (pos.at_s),
        .s_val      (s_val),
        .s_first    (s_first),
        .load_word  (byte_req),
        .word       (sent),
        .ser_out    (ser_out),
        .frame_sync (frame_sync),
        .sf_sync    (sf_sync)
    );

endmodule

// File: rtl/ds1_sf_framer_chk.sv
module ds1_sf_framer_chk #(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            byte_req,
    input logic [CH_W-1:0] req_ch,
    input logic            ser_out,
    input logic            frame_sync,
    input logic            sf_sync
);

    localparam int FRAME_BITS = 1 + 8 * NUM_CH;

    int              bit_cnt;
    logic            seen_fs;
    int              frm_cnt;
    logic            seen_sf;
    logic [CH_W-1:0] last_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= 0;
            seen_fs <= 1'b0;
            frm_cnt <= 0;
            seen_sf <= 1'b0;
            last_ch <= '0;
        end else begin
            if (frame_sync) begin
                bit_cnt <= 0;
                seen_fs <= 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1;
            end
            if (sf_sync) begin
                frm_cnt <= 0;
                seen_sf <= 1'b1;
            end else if (frame_sync) begin
                frm_cnt <= frm_cnt + 1;
            end
            if (byte_req)
                last_ch <= req_ch;
        end
    end

    // R2: framing bits are exactly one frame apart
    a_r2_frame_len: assert property (@(posedge clk) disable iff (rst)
        seen_fs |-> (frame_sync == (bit_cnt == FRAME_BITS - 1)));

    // R3: superframe strobe only on a framing bit
    a_r3_sf_on_fs: assert property (@(posedge clk) disable iff (rst)
        sf_sync |-> frame_sync);

    // R3: superframe strobe every twelfth frame
    a_r3_sf_period: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && seen_sf) |-> (sf_sync == (frm_cnt == 11)));

    // R4: framing bit of frame 1 is a one
    a_r4_first_s_one: assert property (@(posedge clk) disable iff (rst)
        sf_sync |-> ser_out);

    // R9: first request of a frame falls in the framing-bit cycle
    a_r9_req_at_s: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> (byte_req && req_ch == '0));

    // R5: requests are single-cycle
    a_r5_req_gap: assert property (@(posedge clk) disable iff (rst)
        byte_req |=> !byte_req);

    // R9: channel index climbs by one within a frame
    a_r9_ch_step: assert property (@(posedge clk) disable iff (rst)
        (byte_req && !frame_sync) |-> (req_ch == last_ch + CH_W'(1)));

endmodule

bind ds1_sf_framer ds1_sf_framer_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .byte_req   (byte_req),
    .req_ch     (req_ch),
    .ser_out    (ser_out),
    .frame_sync (frame_sync),
    .sf_sync    (sf_sync)
);

// File: tb/ds1_sf_framer_tb.sv
`timescale 1ns/1ps
module ds1_sf_framer_tb_top;

    localparam int NC   = 3;
    localparam int CW   = (NC > 1) ? $clog2(NC) : 1;
    localparam int FB   = 1 + 8 * NC;

    logic          clk = 1'b0;
    logic          rst;
    logic          byte_req;
    logic [CW-1:0] req_ch;
    logic [7:0]    byte_in;
    logic [NC-1:0] sig_a;
    logic [NC-1:0] sig_b;
    logic          ser_out;
    logic          frame_sync;
    logic          sf_sync;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    ds1_sf_framer #(.NUM_CH(NC)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .byte_req   (byte_req),
        .req_ch     (req_ch),
        .byte_in    (byte_in),
        .sig_a      (sig_a),
        .sig_b      (sig_b),
        .ser_out    (ser_out),
        .frame_sync (frame_sync),
        .sf_sync    (sf_sync)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int gen_byte(int f, int ch);
        int k;
        k = (f * 7 + ch * 3) % 6;
        case (k)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 128;
            default: return ((f * 37 + ch * 11 + 5) * 13) % 256;
        endcase
    endfunction

    function automatic int gen_sa(int f, int ch);
        return (((f + ch) % 3) == 0) ? 1 : 0;
    endfunction

    function automatic int gen_sb(int f, int ch);
        return (((f + 2 * ch) % 2) == 1) ? 1 : 0;
    endfunction

    // expected line bit at frame f, bit position pos; tag names the rule
    function automatic int exp_bit(int f, int pos, output string tag);
        int odd_pat[6];
        int even_pat[6];
        int n, ch, b, w, raw;
        odd_pat  = '{1, 0, 1, 0, 1, 0};
        even_pat = '{0, 0, 1, 1, 1, 0};
        n = (f % 12) + 1;
        if (pos == 0) begin
            tag = "R4";
            if (n % 2 == 1) return odd_pat[(n - 1) / 2];
            return even_pat[n / 2 - 1];
        end
        ch  = (pos - 1) / 8;
        b   = (pos - 1) % 8;
        raw = gen_byte(f, ch);
        w   = raw;
        if (n == 6)  w = (w & 254) | gen_sa(f, ch);
        if (n == 12) w = (w & 254) | gen_sb(f, ch);
        tag = "R5";
        if (b == 7) tag = (n == 6 || n == 12) ? "R6" : "R7";
        if ((w & 253) == 0) begin
            w = w | 2;
            if (b == 6) tag = "R8";
        end
        return (w >> (7 - b)) & 1;
    endfunction

    task automatic run_cycles(int ncyc);
        int f, pos, np, nf, ch, e;
        string tag;
        f = 0;
        pos = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            e = exp_bit(f, pos, tag);
            chk(tag, "ser_out", int'(ser_out), e);
            chk("R2", "frame_sync", int'(frame_sync), (pos == 0) ? 1 : 0);
            chk("R3", "sf_sync", int'(sf_sync), (pos == 0 && f % 12 == 0) ? 1 : 0);
            np = pos + 1;
            nf = f;
            if (np == FB) begin
                np = 0;
                nf = f + 1;
            end
            chk("R5", "byte_req", int'(byte_req),
                (np != 0 && ((np - 1) % 8) == 0) ? 1 : 0);
            if (np != 0 && ((np - 1) % 8) == 0) begin
                ch = (np - 1) / 8;
                chk("R9", "req_ch", int'(req_ch), ch);
                byte_in   = 8'(gen_byte(nf, ch));
                sig_a[ch] = gen_sa(nf, ch)[0];
                sig_b[ch] = gen_sb(nf, ch)[0];
            end else begin
                // junk outside a request: must be ignored (R5)
                byte_in = 8'(8'h5A ^ np);
                sig_a   = ~sig_a;
                sig_b   = ~sig_b;
            end
            pos = np;
            f   = nf;
        end
    endtask

    task automatic check_reset_quiet(int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            chk("R1", "ser_out in reset", int'(ser_out), 0);
            chk("R1", "frame_sync in reset", int'(frame_sync), 0);
            chk("R1", "sf_sync in reset", int'(sf_sync), 0);
            chk("R1", "byte_req in reset", int'(byte_req), 0);
        end
    endtask

    initial begin
        rst     = 1'b1;
        byte_in = 8'h00;
        sig_a   = '0;
        sig_b   = '1;
        check_reset_quiet(3);
        rst = 1'b0;
        // three full superframes and a partial frame
        run_cycles(36 * FB + 14);
        rst = 1'b1;
        // R1: reset mid-frame, then restart at frame 1
        check_reset_quiet(3);
        rst = 1'b0;
        run_cycles(13 * FB + 3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule